// File: doc/BRIEF.md
# Buffered 16-bit Tick Timer

This block is a byte-addressed timer peripheral that counts ticks of the instruction cycle. A one-cycle tick-enable input advances it, so it runs on the system clock and needs no second clock. One control byte holds the run bit, the counting width (8-bit or 16-bit), a prescaler bypass bit and a 3-bit ratio code. When the prescaler is in use, ratio code k divides the tick stream by 2^(k+1).

Software never touches the live high byte of the counter directly. It goes through a shadow byte instead:
- Reading the low byte captures the live high byte into the shadow.
- Writing the low byte transfers the shadow into the live high byte in the same cycle.

Either way, a 16-bit value is read or written as one coherent step. A wrap of the active width sets an overflow flag. The flag drives an interrupt request when both a local enable and a global enable are set. Each register access is a single-cycle strobe carrying an address, a write or read enable, and a data byte. Read data is a combinational view of the addressed register.

Top module: `tick_timer16`

## Requirements
- R1: After reset the control byte (address 0) reads 0xFF. The low byte (1), the shadow (2) and the status byte (3) read 0x00, and `irq` is low.
- R2: A write to address 2 loads only the shadow. The live high byte keeps its value, which a following low-byte read captures into the shadow.
- R3: A write to address 1 loads the low byte from the bus and copies the shadow into the live high byte at the same clock edge.
- R4: A read strobe on address 1 copies the live high byte into the shadow. Clearing the shadow through address 2 leaves the counter unchanged.
- R5: While the run bit (control bit 7) is 0, the counter never changes except by register writes.
- R6: With the run bit set and bypass (control bit 3) set, the counter advances once per clock in which `tick_en` is high, and not otherwise.
- R7: With bypass clear, ratio code k (control bits 2:0) advances the counter once every 2^(k+1) enabled ticks. A low-byte write restarts the prescaler, so the next advance comes a full period after that write.
- R8: With control bit 6 set (8-bit width), only the low byte counts. Its wrap from 0xFF to 0x00 sets the flag, and the high byte is untouched.
- R9: With control bit 6 clear, the counter counts as 16 bits and sets the flag on the wrap from 0xFFFF to 0x0000.
- R10: In the status byte (address 3), bit 0 is the flag, bit 1 the local enable and bit 2 the global enable; the other bits read 0. `irq` is high exactly when all three are set. Writing the status byte loads all three bits, but an overflow at the same edge leaves the flag set.
- R11: Control bits 5:4 are plain storage that reads back as written. Mixed random register traffic stays consistent with R1 to R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_en | input | 1 | One-cycle count enable (instruction-cycle tick) |
| bus_addr | input | 2 | Register select: 0 control, 1 low byte, 2 shadow high byte, 3 status |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle; only matters at address 1 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data of the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
A wrong prescaler phase shows at the ports as a low byte that steps one tick early or late. This becomes visible within at most 256 ticks of a low-byte write, and the per-cycle comparison catches it at the first misplaced step. A corrupted live high byte stays hidden until the next low-byte read copies it into the shadow, so the bench reads low then high after every operation that should or should not touch it. A flag that sets on the wrong wrap appears at the status byte and on `irq` on the very next cycle.

// File: rtl/tick_timer16_pkg.sv
`timescale 1ns/1ps
package tick_timer16_pkg;
  localparam int BYTE_W  = 8;
  localparam int RATIO_W = 3;

  // register select codes; firmware depends on them
  localparam logic [1:0] ADR_CTRL = 2'd0;
  localparam logic [1:0] ADR_LOW  = 2'd1;
  localparam logic [1:0] ADR_HIGH = 2'd2;
  localparam logic [1:0] ADR_STAT = 2'd3;

  // control byte, MSB first: run(7) narrow(6) spare(5:4) bypass(3) ratio(2:0)
  typedef struct packed {
    logic               run;
    logic               narrow;
    logic [1:0]         spare;
    logic               bypass;
    logic [RATIO_W-1:0] ratio;
  } ctrl_t;
endpackage

// File: rtl/tick_timer16_psc.sv
`timescale 1ns/1ps
module tick_timer16_psc #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               advance,
  input  logic               restart,
  input  logic               bypass,
  input  logic [RATIO_W-1:0] ratio,
  output logic               step
);
  localparam int PSC_W = 1 << RATIO_W;

  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] psc_d;
  logic [PSC_W-1:0] mask;
  logic             psc_en;

  // bits 0..ratio take part in the terminal-count compare
  for (genvar g = 0; g < PSC_W; g++) begin : g_mask
    assign mask[g] = (RATIO_W'(g) <= ratio);
  end

  always_comb begin
    psc_d = psc_q;
    if (restart)      psc_d = '0;
    else if (advance) psc_d = psc_q + 1'b1;
  end

  assign psc_en = restart | advance;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      psc_q <= '0;
    else if (psc_en) psc_q <= psc_d;
  end

  assign step = advance & (bypass | (&(psc_q | ~mask)));
endmodule

// File: rtl/tick_timer16_cnt.sv
`timescale 1ns/1ps
module tick_timer16_cnt #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic                narrow,
  input  logic                load_lo,
  input  logic                load_hi,
  input  logic                capture,
  input  logic [BYTE_W-1:0]   wdata,
  output logic [2*BYTE_W-1:0] cnt_q,
  output logic [BYTE_W-1:0]   shadow_q,
  output logic                wrap
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [CNT_W-1:0]  cnt_d;
  logic [BYTE_W-1:0] shadow_d;
  logic              cnt_en;
  logic              sh_en;

  always_comb begin
    cnt_d = cnt_q;
    wrap  = 1'b0;
    if (load_lo) begin
      cnt_d = {shadow_q, wdata};
    end else if (step) begin
      if (narrow) begin
        cnt_d[BYTE_W-1:0] = cnt_q[BYTE_W-1:0] + 1'b1;
        wrap              = &cnt_q[BYTE_W-1:0];
      end else begin
        cnt_d = cnt_q + 1'b1;
        wrap  = &cnt_q;
      end
    end
  end

  always_comb begin
    shadow_d = shadow_q;
    if (load_hi)      shadow_d = wdata;
    else if (capture) shadow_d = cnt_q[CNT_W-1:BYTE_W];
  end

  assign cnt_en = load_lo | step;
  assign sh_en  = load_hi | capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shadow_q <= '0;
    else if (sh_en) shadow_q <= shadow_d;
  end
endmodule

// File: rtl/tick_timer16_irq.sv
`timescale 1ns/1ps
module tick_timer16_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrap,
  input  logic       load,
  input  logic [2:0] wbits,
  output logic       flag_q,
  output logic       local_q,
  output logic       global_q,
  output logic       irq
);
  logic flag_d;
  logic flag_en;

  // overflow wins over a clearing write at the same edge
  assign flag_d  = wrap | (load ? wbits[0] : flag_q);
  assign flag_en = wrap | load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      local_q  <= 1'b0;
      global_q <= 1'b0;
    end else if (load) begin
      local_q  <= wbits[1];
      global_q <= wbits[2];
    end
  end

  assign irq = flag_q & local_q & global_q;
endmodule

// File: rtl/tick_timer16.sv
`timescale 1ns/1ps
module tick_timer16
  import tick_timer16_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  ctrl_t             ctrl_q;
  logic              wr_ctrl, wr_low, wr_high, wr_stat, rd_low;
  logic              advance, step, wrap;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shadow_q;
  logic              flag_q, local_q, global_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_ctrl = bus_wr & (bus_addr == ADR_CTRL);
  assign wr_low  = bus_wr & (bus_addr == ADR_LOW);
  assign wr_high = bus_wr & (bus_addr == ADR_HIGH);
  assign wr_stat = bus_wr & (bus_addr == ADR_STAT);
  assign rd_low  = bus_rd & ~bus_wr & (bus_addr == ADR_LOW);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   ctrl_q <= '1;
    else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
  end

  assign advance = ctrl_q.run & tick_en;

  tick_timer16_psc #(.RATIO_W(RATIO_W)) u_psc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .advance (advance),
    .restart (wr_low),
    .bypass  (ctrl_q.bypass),
    .ratio   (ctrl_q.ratio),
    .step    (step)
  );

  tick_timer16_cnt #(.BYTE_W(BYTE_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .step     (step),
    .narrow   (ctrl_q.narrow),
    .load_lo  (wr_low),
    .load_hi  (wr_high),
    .capture  (rd_low),
    .wdata    (bus_wdata),
    .cnt_q    (cnt_q),
    .shadow_q (shadow_q),
    .wrap     (wrap)
  );

  tick_timer16_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wrap     (wrap),
    .load     (wr_stat),
    .wbits    (bus_wdata[2:0]),
    .flag_q   (flag_q),
    .local_q  (local_q),
    .global_q (global_q),
    .irq      (irq)
  );

  always_comb begin
    unique case (bus_addr)
      ADR_CTRL: bus_rdata = ctrl_q;
      ADR_LOW:  bus_rdata = cnt_q[BYTE_W-1:0];
      ADR_HIGH: bus_rdata = shadow_q;
      default:  bus_rdata = {{(BYTE_W-3){1'b0}}, global_q, local_q, flag_q};
    endcase
  end
endmodule

// File: rtl/tick_timer16_chk.sv
`timescale 1ns/1ps
module tick_timer16_chk
  import tick_timer16_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [7:0]        ctrl_q,
  input logic [15:0]       cnt_q,
  input logic [7:0]        shadow_q,
  input logic              flag_q
);
  assert_hi_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_HIGH && !ctrl_q[7]) |=> ($stable(cnt_q) && shadow_q == $past(bus_wdata)));

  assert_lo_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == ADR_LOW) |=> (cnt_q == {$past(shadow_q), $past(bus_wdata)}));

  assert_lo_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == ADR_LOW) |=> (shadow_q == $past(cnt_q[15:8])));

  assert_stopped_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[7] && !(bus_wr && bus_addr == ADR_LOW)) |=> $stable(cnt_q));

  assert_narrow_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && !(bus_wr && bus_addr == ADR_LOW)) |=> $stable(cnt_q[15:8]));

  assert_flag_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && !$past(bus_wr && bus_addr == ADR_STAT)) |-> (cnt_q[7:0] == 8'h00));
endmodule

bind tick_timer16 tick_timer16_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .ctrl_q    (ctrl_q),
  .cnt_q     (cnt_q),
  .shadow_q  (shadow_q),
  .flag_q    (flag_q)
);

// File: tb/sim_tick_timer16.sv
`timescale 1ns/1ps
module sim_tick_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_err = 0;
  string tag = "R1";

  // behavioural model state
  int m_ctrl, m_cnt, m_sh, m_psc, m_flag, m_le, m_ge;

  always #2.5 clk = ~clk;

  tick_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_rd(input int a);
    case (a)
      0: return m_ctrl;
      1: return m_cnt % 256;
      2: return m_sh;
      default: return m_ge * 4 + m_le * 2 + m_flag;
    endcase
  endfunction

  task automatic model_step(input int a, input bit w, input bit r, input int d, input bit t);
    int run, nar, byp, k, per, hi, lo, ovf, inc;
    run = (m_ctrl >> 7) & 1;
    nar = (m_ctrl >> 6) & 1;
    byp = (m_ctrl >> 3) & 1;
    k   = m_ctrl & 7;
    per = 2 << k;
    hi  = m_cnt / 256;
    lo  = m_cnt % 256;
    ovf = 0;
    inc = 0;
    if (run == 1 && t) inc = (byp == 1 || (m_psc % per) == per - 1) ? 1 : 0;
    if (w && a == 1) begin
      m_cnt = m_sh * 256 + d;
      m_psc = 0;
    end else begin
      if (run == 1 && t) m_psc = (m_psc + 1) % 256;
      if (inc == 1) begin
        if (nar == 1) begin
          ovf = (lo == 255) ? 1 : 0;
          m_cnt = hi * 256 + (lo + 1) % 256;
        end else begin
          ovf = (m_cnt == 65535) ? 1 : 0;
          m_cnt = (m_cnt + 1) % 65536;
        end
      end
    end
    if (w && a == 2) m_sh = d;
    else if (r && !w && a == 1) m_sh = hi;
    if (w && a == 0) m_ctrl = d;
    if (w && a == 3) begin
      m_flag = d & 1;
      m_le = (d >> 1) & 1;
      m_ge = (d >> 2) & 1;
    end
    if (ovf == 1) m_flag = 1;
  endtask

  // one bus cycle, compared against the model after the edge
  task automatic cyc(input int a, input bit w, input bit r, input int d, input bit t);
    bus_addr = 2'(a); bus_wr = w; bus_rd = r; bus_wdata = 8'(d); tick_en = t;
    @(posedge clk);
    model_step(a, w, r, d, t);
    @(negedge clk);
    chk(tag, 16'(bus_rdata), 16'(model_rd(a)));
    chk(tag, 16'(irq), 16'(m_flag & m_le & m_ge));
  endtask

  task automatic wr(input int a, input int d);  cyc(a, 1, 0, d, 0); endtask
  task automatic rd(input int a);               cyc(a, 0, 1, 0, 0); endtask
  task automatic peek(input int a);             cyc(a, 0, 0, 0, 0); endtask
  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    m_ctrl = 255; m_cnt = 0; m_sh = 0; m_psc = 0; m_flag = 0; m_le = 0; m_ge = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset values
    tag = "R1";
    peek(0); chk("R1 ctrl", 16'(bus_rdata), 16'hFF);
    peek(1); chk("R1 low", 16'(bus_rdata), 16'h00);
    peek(2); chk("R1 shadow", 16'(bus_rdata), 16'h00);
    peek(3); chk("R1 status", 16'(bus_rdata), 16'h00);
    chk("R1 irq", 16'(irq), 16'h0);

    // R11: spare control bits are storage
    tag = "R11";
    wr(0, 8'h30); peek(0); chk("R11 spare", 16'(bus_rdata), 16'h30);
    wr(0, 8'h00);

    // R3: low write copies shadow into live high byte
    tag = "R3";
    wr(2, 8'h2A); wr(1, 8'h2A);
    peek(1); chk("R3 low", 16'(bus_rdata), 16'h2A);

    // R4: capture on low read, clearing shadow does not touch counter
    tag = "R4";
    wr(2, 8'h00); peek(2); chk("R4 shadow cleared", 16'(bus_rdata), 16'h00);
    rd(1); peek(2); chk("R4 capture", 16'(bus_rdata), 16'h2A);

    // R2: high write touches only the shadow
    tag = "R2";
    wr(2, 8'h55); peek(2); chk("R2 shadow", 16'(bus_rdata), 16'h55);
    rd(1); peek(2); chk("R2 live high kept", 16'(bus_rdata), 16'h2A);

    // R5: stopped timer holds with ticks present
    tag = "R5";
    run_ticks(20); chk("R5 hold", 16'(bus_rdata), 16'h2A);

    // R6: bypass, one step per tick, irregular tick pattern
    tag = "R6";
    wr(1, 8'h00); wr(0, 8'h88);
    for (int i = 0; i < 60; i++) cyc(1, 0, 0, 0, 1'($urandom_range(0, 1)));

    // R7: every ratio, first step a full period after the low write
    tag = "R7";
    for (int k = 0; k < 8; k++) begin
      wr(0, 8'h00); wr(2, 8'h00); wr(1, 8'h00); wr(0, 8'hC0 | k);
      for (int i = 1; i <= (2 << k) * 2 + 3; i++) begin
        cyc(1, 0, 0, 0, 1);
        if (i == (2 << k) - 1) chk("R7 before period", 16'(bus_rdata), 16'h00);
        if (i == (2 << k))     chk("R7 at period", 16'(bus_rdata), 16'h01);
      end
    end
    wr(0, 8'hC2); run_ticks(5); wr(1, 8'h10);
    run_ticks(7); chk("R7 restart hold", 16'(bus_rdata), 16'h10);
    run_ticks(1); chk("R7 restart step", 16'(bus_rdata), 16'h11);

    // R8: 8-bit wrap, high untouched, flag and irq
    tag = "R8";
    wr(0, 8'h00); wr(3, 8'h06); wr(2, 8'h37); wr(1, 8'hFA); wr(0, 8'hC8);
    run_ticks(10); chk("R8 low wrapped", 16'(bus_rdata), 16'h04);
    rd(1); peek(2); chk("R8 high kept", 16'(bus_rdata), 16'h37);
    peek(3); chk("R8 flag", 16'(bus_rdata), 16'h07);
    chk("R8 irq", 16'(irq), 16'h1);

    // R9: 16-bit wrap
    tag = "R9";
    wr(3, 8'h06); wr(0, 8'h00); wr(2, 8'hFF); wr(1, 8'hFC); wr(0, 8'h88);
    run_ticks(3); peek(3); chk("R9 no flag at FFFF", 16'(bus_rdata), 16'h06);
    run_ticks(1); chk("R9 low zero", 16'(bus_rdata), 16'h00);
    peek(3); chk("R9 flag", 16'(bus_rdata), 16'h07);
    rd(1); peek(2); chk("R9 high zero", 16'(bus_rdata), 16'h00);

    // R10: enable combinations and overflow beating a clear
    tag = "R10";
    wr(0, 8'h00);
    wr(3, 8'h01); chk("R10 flag only", 16'(irq), 16'h0);
    wr(3, 8'h03); chk("R10 no global", 16'(irq), 16'h0);
    wr(3, 8'h05); chk("R10 no local", 16'(irq), 16'h0);
    wr(3, 8'h07); chk("R10 all set", 16'(irq), 16'h1);
    wr(3, 8'h06); chk("R10 cleared", 16'(irq), 16'h0);
    wr(1, 8'hFE); wr(0, 8'hC8);
    cyc(1, 0, 0, 0, 1);
    cyc(3, 1, 0, 8'h06, 1);
    chk("R10 overflow wins", 16'(bus_rdata), 16'h07);

    // R11: mixed random traffic against the model
    tag = "R11";
    for (int i = 0; i < 600; i++) begin
      bit w;
      w = ($urandom_range(0, 3) == 0);
      cyc(int'($urandom_range(0, 3)), w, 1'($urandom_range(0, 1)),
          int'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
    end

    summary();
    $finish;
  end
endmodule